// File: doc/BRIEF.md
# Armed Analog Level Trigger

This block watches a stream of 8-bit converter samples and raises a single-cycle trigger pulse when the signal rises through a programmable level. It only fires after it has been armed. Arming happens when the signal first drops to or below a second, lower level. Because of this split between arming and firing, noise riding on a slow edge cannot cause repeated triggers near the firing level. The signal must go back down past the arm level before the block can fire again.

Both levels come from one packed 16-bit configuration word. The same word also carries a two-bit filter-length selector. The block decodes that selector into a tap count for the sample path and presents the count as an output. The two least significant bits of each level are not used, so both levels move in steps of 4 counts. A configuration write takes effect on the next cycle and always leaves the block disarmed.

Top module: `armed_level_trigger`

## Requirements
- R1: After reset the armed output and the trigger pulse are low, the firing level is 0x90, the arm level is 0x70 and the tap count is 68 (selector 0).
- R2: When the block is not armed and sampleValid is high, a sample less than or equal to the effective arm level sets armed in the next cycle.
- R3: When the block is armed and sampleValid is high, a sample greater than or equal to the effective firing level raises trigPulse for exactly one cycle, starting in the next cycle. In that same cycle armed returns low.
- R4: While the block is not armed, no sample produces a trigger pulse, however high it is. While it is armed, samples below the firing level leave it armed and do not fire.
- R5: The effective levels are the configured levels with bits 1:0 forced to zero, so each level has a resolution of 4 counts.
- R6: In cfgWord, bits 15:8 hold the firing level, bits 7:0 hold the arm level, and bits 1:0 hold the filter selector.
- R7: The tap count is 68 for selector 0, 45 for selector 1 and 28 for selector 2. Selector 3 gives 68, the same as selector 0.
- R8: A cycle with cfgWrite high clears armed in the next cycle. Any sample presented in that same cycle is disregarded.
- R9: A sample presented while sampleValid is low has no effect on armed or trigPulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrite | input | 1 | Load cfgWord this cycle |
| cfgWord | input | 16 | Packed firing level, arm level and filter selector |
| sampleValid | input | 1 | Sample qualifier |
| sample | input | 8 | Converter sample |
| armed | output | 1 | Block is armed and waiting for the firing level |
| trigPulse | output | 1 | One-cycle trigger indication |
| tapLen | output | 7 | Decoded filter tap count |

## Verification
The trigger path is exercised with four kinds of sample sequence:
- A falling-then-rising sequence around the default levels checks that arming and firing both happen at equality and one count outside it.
- A high sample while disarmed checks that the arm step comes before any firing.
- A sequence against a configured word whose levels have nonzero low bits shows whether those bits are dropped.
- Samples that coincide with a configuration write or have sampleValid low must leave the state untouched, which shows that the input qualification is correct.

All four selector values are loaded to check the tap decode and its wrap of selector 3.

// File: rtl/alt_pkg.sv
package alt_pkg;
  typedef struct packed {
    logic loadCfg;
    logic sampleTake;
  } ctrlStrobeT;
endpackage

// File: rtl/alt_datapath.sv
module alt_datapath
  import alt_pkg::*;
#(
  parameter int SampleW = 8,
  parameter int TapW = 7,
  parameter logic [SampleW-1:0] DefTrig = 8'h90,
  parameter logic [SampleW-1:0] DefArm = 8'h70,
  parameter int Taps0 = 68,
  parameter int Taps1 = 45,
  parameter int Taps2 = 28
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrlStrobeT           strobes,
  input  logic [2*SampleW-1:0] cfgWord,
  input  logic [SampleW-1:0]   sample,
  output logic                 armHit,
  output logic                 fireHit,
  output logic [TapW-1:0]      tapLen
);
  localparam int CfgW = 2 * SampleW;
  localparam logic [SampleW-1:0] LowMask = {{(SampleW-2){1'b1}}, 2'b00};

  logic [SampleW-1:0] trigLevel;
  logic [SampleW-1:0] armLevel;
  logic [1:0]         filtSel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trigLevel <= DefTrig & LowMask;
      armLevel  <= DefArm & LowMask;
      filtSel   <= 2'd0;
    end else if (strobes.loadCfg) begin
      trigLevel <= cfgWord[CfgW-1:SampleW] & LowMask;
      armLevel  <= cfgWord[SampleW-1:0] & LowMask;
      filtSel   <= cfgWord[1:0];
    end
  end

  always_comb begin
    armHit  = strobes.sampleTake && (sample <= armLevel);
    fireHit = strobes.sampleTake && (sample >= trigLevel);
  end

  always_comb begin
    unique case (filtSel)
      2'd1:    tapLen = TapW'(Taps1);
      2'd2:    tapLen = TapW'(Taps2);
      default: tapLen = TapW'(Taps0);
    endcase
  end

  // R7: decode follows the loaded selector, with selector 3 wrapping to 0
  a_r7_sel3_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobes.loadCfg) && ($past(cfgWord[1:0]) == 2'd3) |-> tapLen == TapW'(Taps0));
  a_r7_sel2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobes.loadCfg) && ($past(cfgWord[1:0]) == 2'd2) |-> tapLen == TapW'(Taps2));
endmodule

// File: rtl/alt_control.sv
module alt_control
  import alt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgWrite,
  input  logic       sampleValid,
  input  logic       armHit,
  input  logic       fireHit,
  output ctrlStrobeT strobes,
  output logic       armed,
  output logic       trigPulse
);
  always_comb begin
    strobes.loadCfg    = cfgWrite;
    strobes.sampleTake = sampleValid && !cfgWrite;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      trigPulse <= 1'b0;
    end else begin
      trigPulse <= 1'b0;
      if (cfgWrite) begin
        armed <= 1'b0;
      end else if (armed && fireHit) begin
        armed     <= 1'b0;
        trigPulse <= 1'b1;
      end else if (!armed && armHit) begin
        armed <= 1'b1;
      end
    end
  end

  // R3: a pulse follows an armed cycle, leaves the block disarmed, and lasts one cycle
  a_r3_pulse_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    trigPulse |-> $past(armed));
  a_r3_pulse_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    trigPulse |-> !armed);
  a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    trigPulse |=> !trigPulse);
  // R8: a configuration write leaves the block disarmed
  a_r8_cfg_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    cfgWrite |=> !armed && !trigPulse);
  // R9: without a valid sample nothing changes
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleValid && !cfgWrite |=> $stable(armed) && !trigPulse);
endmodule

// File: rtl/armed_level_trigger.sv
module armed_level_trigger
  import alt_pkg::*;
#(
  parameter int SampleW = 8,
  parameter int TapW = 7,
  parameter int Taps0 = 68,
  parameter int Taps1 = 45,
  parameter int Taps2 = 28
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfgWrite,
  input  logic [2*SampleW-1:0] cfgWord,
  input  logic                 sampleValid,
  input  logic [SampleW-1:0]   sample,
  output logic                 armed,
  output logic                 trigPulse,
  output logic [TapW-1:0]      tapLen
);
  ctrlStrobeT strobes;
  logic armHit;
  logic fireHit;

  alt_control u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgWrite(cfgWrite), .sampleValid(sampleValid),
    .armHit(armHit), .fireHit(fireHit), .strobes(strobes),
    .armed(armed), .trigPulse(trigPulse)
  );

  alt_datapath #(
    .SampleW(SampleW), .TapW(TapW),
    .DefTrig(SampleW'(8'h90)), .DefArm(SampleW'(8'h70)),
    .Taps0(Taps0), .Taps1(Taps1), .Taps2(Taps2)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .cfgWord(cfgWord),
    .sample(sample), .armHit(armHit), .fireHit(fireHit), .tapLen(tapLen)
  );
endmodule

// File: tb/sim_armed_level_trigger.sv
module sim_armed_level_trigger;
  localparam int ClkPeriod = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgWrite = 1'b0;
  logic [15:0] cfgWord = 16'h0;
  logic sampleValid = 1'b0;
  logic [7:0] sample = 8'h0;
  logic armed, trigPulse;
  logic [6:0] tapLen;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  armed_level_trigger u0 (
    .clk(clk), .rst_n(rst_n), .cfgWrite(cfgWrite), .cfgWord(cfgWord),
    .sampleValid(sampleValid), .sample(sample),
    .armed(armed), .trigPulse(trigPulse), .tapLen(tapLen)
  );

  task automatic check(string req, int actual, int expected);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic sendSample(logic [7:0] v, logic valid = 1'b1);
    @(negedge clk);
    sampleValid = valid;
    sample = v;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic writeCfg(logic [15:0] w);
    @(negedge clk);
    cfgWrite = 1'b1;
    cfgWord = w;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic testReset();
    check("R1 armed", armed, 0);
    check("R1 pulse", trigPulse, 0);
    check("R1 taps", tapLen, 68);
  endtask

  task automatic testDefaults();
    sendSample(8'h71);
    check("R1 0x71 above default arm", armed, 0);
    sendSample(8'h70);
    check("R2 arm at equality", armed, 1);
    sendSample(8'h10);
    check("R4 stays armed low sample", armed, 1);
    sendSample(8'h8F);
    check("R4 no fire below level", trigPulse, 0);
    check("R4 still armed", armed, 1);
    sendSample(8'h90);
    check("R3 fire at equality", trigPulse, 1);
    check("R3 disarmed on fire", armed, 0);
    @(negedge clk);
    check("R3 pulse one cycle", trigPulse, 0);
  endtask

  task automatic testDisarmedHigh();
    sendSample(8'hFF);
    check("R4 no fire while disarmed", trigPulse, 0);
    check("R4 high sample does not arm", armed, 0);
  endtask

  task automatic testLowBits();
    writeCfg(16'h9373);
    check("R7 selector 3 wraps", tapLen, 68);
    sendSample(8'h73);
    check("R5 arm level low bits dropped", armed, 0);
    sendSample(8'h70);
    check("R5 arm at masked level", armed, 1);
    sendSample(8'h90);
    check("R5 fire at masked level", trigPulse, 1);
  endtask

  task automatic testFieldsAndTaps();
    writeCfg(16'h4021);
    check("R7 selector 1", tapLen, 45);
    sendSample(8'h24);
    check("R6 arm field position", armed, 0);
    sendSample(8'h20);
    check("R6 arm from low byte", armed, 1);
    sendSample(8'h3C);
    check("R6 below fire field", trigPulse, 0);
    sendSample(8'h40);
    check("R6 fire from high byte", trigPulse, 1);
    writeCfg(16'h4022);
    check("R7 selector 2", tapLen, 28);
    writeCfg(16'h4020);
    check("R7 selector 0", tapLen, 68);
  endtask

  task automatic testCfgClears();
    sendSample(8'h00);
    check("R2 arm before write", armed, 1);
    writeCfg(16'h9070);
    check("R8 write clears armed", armed, 0);
    @(negedge clk);
    cfgWrite = 1'b1;
    cfgWord = 16'h9070;
    sampleValid = 1'b1;
    sample = 8'h00;
    @(negedge clk);
    cfgWrite = 1'b0;
    sampleValid = 1'b0;
    check("R8 sample during write ignored", armed, 0);
  endtask

  task automatic testInvalid();
    sendSample(8'h00, 1'b0);
    check("R9 invalid sample no arm", armed, 0);
    sendSample(8'h00);
    check("R9 valid arms", armed, 1);
    sendSample(8'hFF, 1'b0);
    check("R9 invalid sample no fire", trigPulse, 0);
    check("R9 still armed", armed, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testDefaults();
    testDisarmedHigh();
    testLowBits();
    testFieldsAndTaps();
    testCfgClears();
    testInvalid();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule